// File: doc/BRIEF.md
# Smart card character transmitter

This block drives one half-duplex smart card data line. A single write strobe loads a data byte. The block then sends a character made of a low start bit, the eight data bits with the least significant bit first, and a parity bit. Each bit lasts one elementary time unit (etu). After the parity bit the line returns high and stays there until the next accepted write.

The etu length has two factors. The first is a prescaler on the system clock, which divides by 1, 4, 16 or 64. The second is the number of base clock pulses per etu, which is 32, 64, 372 or 256. Internally the block counts half-etus, so the end-of-character flag can rise at a fractional etu point. Three operating modes set that point: a plain character mode, a block transfer mode and a GSM mode.

The configuration is captured when a write is accepted. Later changes to it cannot disturb a character that is already being sent. The card clock control is the exception: it follows its inputs directly. In GSM mode it can also hold the clock at a fixed high level.

Top module: `sc_char_tx`

## Requirements
- R1: A synchronous active-high reset, even in the middle of a character, drives `sio` high and `tx_end` low and stops all counting.
- R2: A write strobe while idle starts a character one cycle later. The line is low for one etu, then carries `wr_data` bit 0 through bit 7 for one etu each. After the parity bit the line is high.
- R3: The parity bit follows bit 7. With `cfg_odd`=0 the eight data bits plus parity hold an even number of ones. With `cfg_odd`=1 they hold an odd number.
- R4: One etu equals D×P system clocks. D is 1, 4, 16 or 64 for `cfg_prescale` codes 0, 1, 2 and 3. P is 32, 64, 372 or 256 for `cfg_bcp` codes 0, 1, 2 and 3.
- R5: With `cfg_gsm`=0 and `cfg_block`=0, `tx_end` rises exactly 12.5 etu after the start bit begins.
- R6: With `cfg_gsm`=0 and `cfg_block`=1, `tx_end` rises exactly 11.5 etu after the start bit begins.
- R7: With `cfg_gsm`=1, `tx_end` rises exactly 11.0 etu after the start bit begins, whatever `cfg_block` is.
- R8: `tx_end` stays high until a write is accepted. An accepted write clears it one cycle after the strobe.
- R9: A write strobe during a character is ignored. The line contents and the timing of `tx_end` do not change.
- R10: `cfg_ck` selects the card clock. Code 1 gives `ck_run`=1. Codes 0, 2 and 3 give `ck_run`=0. `ck_level` is 1 only when `cfg_ck`=3 and `cfg_gsm`=1, and 0 otherwise.
- R11: Changes to the parity, prescaler, pulse count or mode inputs during a character do not affect that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_prescale | input | 2 | Prescaler code (divide by 1/4/16/64) |
| cfg_bcp | input | 2 | Base pulses per etu code (32/64/372/256) |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_block | input | 1 | Block transfer mode select |
| cfg_gsm | input | 1 | GSM mode select, has priority over block mode |
| cfg_ck | input | 2 | Card clock control code |
| wr_stb | input | 1 | Write strobe for a new character |
| wr_data | input | 8 | Character data |
| sio | output | 1 | Serial data line |
| ck_run | output | 1 | Card clock toggling enable |
| ck_level | output | 1 | Static card clock level when not toggling |
| tx_end | output | 1 | Character end flag |

## Verification
Take the edge E at which a write is accepted. Half-etu number n starts on the line right after edge E+n·H, where H is D·P/2 system clocks. `tx_end` rises right after edge E+k·H, with k equal to 25, 23 or 22 depending on the mode. The card clock outputs follow their inputs within the same cycle. The bench keeps its own cycle-count model from the same edge and compares every output at each falling clock edge. It also measures the accept-to-flag distance in whole cycles and checks it against k·H for each mode and each etu setting.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int DATA_W = 8;
  localparam int PS_W   = 6;
  localparam int HC_W   = 9;
  localparam int HALF_W = 5;
  localparam int FRAME_HALVES = 2 * (DATA_W + 2);

  typedef enum logic [1:0] {
    CK_STOP = 2'd0,
    CK_RUN  = 2'd1,
    CK_LOW  = 2'd2,
    CK_HIGH = 2'd3
  } ck_mode_e;

  // prescaler terminal count = divisor - 1
  function automatic logic [PS_W-1:0] prescale_max(input logic [1:0] code);
    case (code)
      2'd0:    return PS_W'(0);
      2'd1:    return PS_W'(3);
      2'd2:    return PS_W'(15);
      default: return PS_W'(63);
    endcase
  endfunction

  // half-etu terminal count = pulses/2 - 1
  function automatic logic [HC_W-1:0] half_max(input logic [1:0] code);
    case (code)
      2'd0:    return HC_W'(15);
      2'd1:    return HC_W'(31);
      2'd2:    return HC_W'(185);
      default: return HC_W'(127);
    endcase
  endfunction

  // last half-etu index before the end flag rises
  function automatic logic [HALF_W-1:0] end_last(input logic blk, input logic gsm);
    if (gsm)      return HALF_W'(FRAME_HALVES + 1);
    else if (blk) return HALF_W'(FRAME_HALVES + 2);
    else          return HALF_W'(FRAME_HALVES + 4);
  endfunction
endpackage

// File: rtl/sc_tx_timer.sv
module sc_tx_timer
  import sc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  input  logic [1:0]        ps_code,
  input  logic [1:0]        bcp_code,
  output logic              half_step,
  output logic [HALF_W-1:0] half_idx
);
  logic [PS_W-1:0] ps_cnt;
  logic [HC_W-1:0] hc;
  logic            tick;

  assign tick      = run && (ps_cnt == prescale_max(ps_code));
  assign half_step = tick && (hc == half_max(bcp_code));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      ps_cnt   <= '0;
      hc       <= '0;
      half_idx <= '0;
    end else if (run) begin
      ps_cnt <= tick ? '0 : ps_cnt + 1'b1;
      if (tick) hc <= half_step ? '0 : hc + 1'b1;
      if (half_step) half_idx <= half_idx + 1'b1;
    end
  end

  // R4
  hc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hc <= half_max(bcp_code));

  // R4
  half_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!half_step && !start) |=> $stable(half_idx));
endmodule

// File: rtl/sc_tx_frame.sv
module sc_tx_frame
  import sc_tx_pkg::*;
(
  input  logic              busy,
  input  logic [HALF_W-1:0] half_idx,
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              sio
);
  function automatic logic line_at(input int bit_no, input logic [DATA_W-1:0] d,
                                   input logic p);
    if (bit_no == 0)           return 1'b0;
    else if (bit_no <= DATA_W) return d[bit_no-1];
    else if (bit_no == DATA_W + 1) return p;
    else                       return 1'b1;
  endfunction

  always_comb begin
    if (!busy) sio = 1'b1;
    else       sio = line_at(int'(half_idx >> 1), data, par);
  end
endmodule

// File: rtl/sc_tx_clkctl.sv
module sc_tx_clkctl
  import sc_tx_pkg::*;
(
  input  logic [1:0] ck_code,
  input  logic       gsm,
  output logic       ck_run,
  output logic       ck_level
);
  ck_mode_e mode;
  assign mode     = ck_mode_e'(ck_code);
  assign ck_run   = (mode == CK_RUN);
  assign ck_level = gsm && (mode == CK_HIGH);
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_prescale,
  input  logic [1:0]        cfg_bcp,
  input  logic              cfg_odd,
  input  logic              cfg_block,
  input  logic              cfg_gsm,
  input  logic [1:0]        cfg_ck,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sio,
  output logic              ck_run,
  output logic              ck_level,
  output logic              tx_end
);
  logic              busy;
  logic [DATA_W-1:0] data_q;
  logic              par_q;
  logic [1:0]        ps_q, bcp_q;
  logic [HALF_W-1:0] last_q;
  logic              half_step;
  logic [HALF_W-1:0] half_idx;
  logic              accept, done;

  assign accept = wr_stb && !busy;
  assign done   = busy && half_step && (half_idx == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tx_end <= 1'b0;
      data_q <= '0;
      par_q  <= 1'b0;
      ps_q   <= '0;
      bcp_q  <= '0;
      last_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      tx_end <= 1'b0;
      data_q <= wr_data;
      par_q  <= (^wr_data) ^ cfg_odd;
      ps_q   <= cfg_prescale;
      bcp_q  <= cfg_bcp;
      last_q <= end_last(cfg_block, cfg_gsm);
    end else if (done) begin
      busy   <= 1'b0;
      tx_end <= 1'b1;
    end
  end

  sc_tx_timer u_timer (
    .clk(clk), .rst(rst), .start(accept), .run(busy),
    .ps_code(ps_q), .bcp_code(bcp_q),
    .half_step(half_step), .half_idx(half_idx)
  );

  sc_tx_frame u_frame (
    .busy(busy), .half_idx(half_idx), .data(data_q), .par(par_q), .sio(sio)
  );

  sc_tx_clkctl u_clk (
    .ck_code(cfg_ck), .gsm(cfg_gsm), .ck_run(ck_run), .ck_level(ck_level)
  );

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !sio);

  // R2
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_end) |-> sio);

  // R5
  end_on_half_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_end) |-> $past(half_step));

  // R8
  end_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_end && !wr_stb) |=> tx_end);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_stb) |=> ($stable(data_q) && $stable(par_q)));
endmodule

// File: tb/sc_char_tx_test.sv
`timescale 1ns/1ps
module sc_char_tx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_prescale = 2'd0, cfg_bcp = 2'd0, cfg_ck = 2'd0;
  logic       cfg_odd = 1'b0, cfg_block = 1'b0, cfg_gsm = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sio, ck_run, ck_level, tx_end;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sc_char_tx uut (
    .clk(clk), .rst(rst), .cfg_prescale(cfg_prescale), .cfg_bcp(cfg_bcp),
    .cfg_odd(cfg_odd), .cfg_block(cfg_block), .cfg_gsm(cfg_gsm), .cfg_ck(cfg_ck),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .sio(sio), .ck_run(ck_run), .ck_level(ck_level), .tx_end(tx_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit       started = 0;
  bit       m_busy = 0, m_end = 0, m_par = 0;
  int       m_t = 0, m_H = 1, m_target = 25;
  bit [7:0] m_byte = 0;

  function automatic int pulses_of(input int code);
    int tbl[4] = '{32, 64, 372, 256};
    return tbl[code];
  endfunction

  always @(posedge clk) begin
    started <= 1;
    cyc++;
    if (rst) begin
      m_busy = 0; m_end = 0;
    end else if (wr_stb && !m_busy) begin
      m_busy = 1; m_end = 0; m_t = 0; m_byte = wr_data;
      m_par = cfg_odd;
      for (int i = 0; i < 8; i++) m_par = m_par ^ wr_data[i];
      m_H = (4 ** cfg_prescale) * pulses_of(cfg_bcp) / 2;
      m_target = cfg_gsm ? 22 : (cfg_block ? 23 : 25);
    end else if (m_busy) begin
      m_t++;
      if (m_t == m_target * m_H) begin m_busy = 0; m_end = 1; end
    end
    if (cyc == 190000) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      int  h, b;
      bit  e_sio;
      e_sio = 1;
      h = m_t / m_H;
      b = h / 2;
      if (m_busy) begin
        if (b == 0) e_sio = 0;
        else if (b <= 8) e_sio = m_byte[b-1];
        else if (b == 9) e_sio = m_par;
      end
      check(sio === e_sio, (m_busy && b == 9) ? "R3 parity bit" : "R2 line", sio, e_sio);
      check(tx_end === m_end, "R5 R6 R7 R8 end flag", tx_end, m_end);
      check(ck_run === (cfg_ck == 2'd1), "R10 ck_run", ck_run, cfg_ck == 2'd1);
      check(ck_level === (cfg_gsm && cfg_ck == 2'd3), "R10 ck_level", ck_level,
            cfg_gsm && cfg_ck == 2'd3);
    end
  end

  // send one character, return cycles from accept edge to tx_end
  task automatic send(input bit [7:0] d, input int mid_at, output int n);
    @(negedge clk);
    wr_stb = 1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 0;
    check(tx_end === 1'b0, "R8 flag cleared by write", tx_end, 0);
    check(sio === 1'b0, "R2 start bit", sio, 0);
    n = 1;
    while (n < 60000) begin
      if (n == mid_at) begin
        wr_stb = 1; wr_data = ~d;
        cfg_odd = ~cfg_odd; cfg_block = ~cfg_block; cfg_prescale = cfg_prescale + 1;
      end else if (n == mid_at + 1) begin
        wr_stb = 0;
        cfg_odd = ~cfg_odd; cfg_block = ~cfg_block; cfg_prescale = cfg_prescale - 1;
      end
      @(negedge clk);
      if (tx_end) break;
      n++;
    end
  endtask

  task automatic run_case(input bit [7:0] d, input int ps, input int bcp,
                          input bit blk, input bit gsm, input bit odd,
                          input int mid_at, input int exp_halves, input string req);
    int n, h;
    cfg_prescale = 2'(ps); cfg_bcp = 2'(bcp); cfg_block = blk; cfg_gsm = gsm;
    cfg_odd = odd;
    h = (4 ** ps) * pulses_of(bcp) / 2;
    send(d, mid_at, n);
    check(n == exp_halves * h, req, n, exp_halves * h);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    check(sio === 1'b1, "R1 reset line high", sio, 1);
    check(tx_end === 1'b0, "R1 reset flag low", tx_end, 0);

    run_case(8'hA5, 0, 0, 0, 0, 0, 0, 25, "R5 normal 12.5 etu");
    repeat (20) @(negedge clk);
    check(tx_end === 1'b1, "R8 flag holds while idle", tx_end, 1);
    run_case(8'hFF, 0, 0, 1, 0, 1, 0, 23, "R6 block 11.5 etu");
    run_case(8'h3C, 0, 2, 1, 1, 0, 0, 22, "R7 gsm over block 11.0 etu");
    run_case(8'h01, 1, 1, 0, 0, 1, 0, 25, "R4 div4 x64");
    run_case(8'h80, 0, 3, 0, 1, 0, 0, 22, "R4 div1 x256");
    run_case(8'h6E, 2, 0, 0, 0, 0, 0, 25, "R4 div16 x32");
    run_case(8'h00, 3, 0, 1, 0, 1, 0, 23, "R4 div64 x32");
    run_case(8'hC3, 0, 1, 0, 0, 0, 300, 25, "R9 R11 mid-character write and config change");

    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        cfg_gsm = 1'(g); cfg_ck = 2'(k);
        #1;
        check(ck_run === (k == 1), "R10 clock run code", ck_run, k == 1);
        check(ck_level === (g == 1 && k == 3), "R10 clock level code", ck_level,
              g == 1 && k == 3);
      end

    cfg_gsm = 0; cfg_block = 0; cfg_prescale = 0; cfg_bcp = 0;
    @(negedge clk); wr_stb = 1; wr_data = 8'h55;
    @(negedge clk); wr_stb = 0;
    repeat (50) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(sio === 1'b1, "R1 mid-character reset line", sio, 1);
    check(tx_end === 1'b0, "R1 mid-character reset flag", tx_end, 0);
    repeat (40) @(negedge clk);
    check(sio === 1'b1, "R1 stays idle after reset", sio, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule